// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core leaves normal execution for debug execution and when it comes back. An external debug port raises a break request. The block holds that request until the core reports an instruction boundary. At that boundary it enters debug mode. On entry it stores the resume address and the current status word in dedicated context registers. It then sends fetch to a fixed break vector, which is the debug window base plus 0x20. Running code can neither cause this entry nor stop it. Entry does not depend on the global interrupt enable. A break request and an interrupt at the same boundary resolve in favour of the break.

A debug-return strobe ends the debug session. Fetch goes back to the stored resume address, and the stored status word is offered for the core to restore. The three context registers are reached through a small register access port. This port works only in debug mode. In normal mode reads return zero, and writes are dropped and reported by a one-cycle illegal-access flag. Redirect and restore outputs are plain one-cycle strobes with no back-pressure: the core must accept a redirect in the cycle it appears.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset is applied, even in the middle of a debug session, `dbg_mode_o`, `redirect_valid_o`, `stat_restore_valid_o` and `ctx_illegal_o` are 0.
- R2: A one-cycle `halt_req_i` pulse in normal mode is remembered until a clock edge where `insn_done_i` is 1. Debug mode starts at that edge, so `dbg_mode_o` is 1 from the next cycle. With `insn_done_i` low, no entry takes place.
- R3: Entry does not depend on `irq_en_i` and takes place with interrupts globally disabled.
- R4: In the cycle after the entry edge, `redirect_valid_o` is 1 for one cycle, with `redirect_pc_o` = `DBG_BASE` + 0x20.
- R5: At the entry edge, `next_pc_i` is stored as the resume address and `status_i` as the saved status. In debug mode both can be read through the access port.
- R6: A `dret_i` pulse in debug mode makes three things true in the next cycle: `dbg_mode_o` is 0, `redirect_valid_o` is 1 with `redirect_pc_o` equal to the stored resume address, and `stat_restore_valid_o` is 1 with the saved status. A `dret_i` pulse in normal mode has no effect.
- R7: A break request that arrives in debug mode is dropped. It neither ends the session nor causes a new entry after the return.
- R8: `irq_grant_o` = `irq_req_i` & `irq_en_i` & `insn_done_i` & normal mode & no debug entry at this edge. This is combinational, so a break at the same boundary wins.
- R9: The access port is selected by `ctx_sel_i`: 0 is the scratch register, 1 is the resume address, 2 is the saved status (zero-extended), and 3 is unmapped. `ctx_rdata_o` is combinational from the selected register in debug mode. It is 0 in normal mode and for select 3.
- R10: A normal-mode write (`ctx_valid_i` & `ctx_write_i`) with select 0 to 2 leaves the registers unchanged and sets `ctx_illegal_o` to 1 for exactly the next cycle. A write with select 3 never raises the flag.
- R11: A debug-mode write updates the selected register. A resume address written this way is the one used by the next return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | Break request from the external debug port |
| insn_done_i | input | 1 | Instruction boundary in this cycle |
| next_pc_i | input | ADDR_W | Address of the next instruction |
| status_i | input | STAT_W | Current status word |
| irq_req_i | input | 1 | Interrupt wants to be taken |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_grant_o | output | 1 | Interrupt entry allowed at this boundary |
| dret_i | input | 1 | Debug-return strobe |
| dbg_mode_o | output | 1 | Core is in debug mode |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | ADDR_W | Redirect target |
| stat_restore_valid_o | output | 1 | Status restore strobe |
| stat_restore_o | output | STAT_W | Status word to restore |
| ctx_valid_i | input | 1 | Access port request |
| ctx_write_i | input | 1 | 1 = write, 0 = read |
| ctx_sel_i | input | 2 | Register select |
| ctx_wdata_i | input | ADDR_W | Write data |
| ctx_rdata_o | output | ADDR_W | Read data |
| ctx_illegal_o | output | 1 | Normal-mode write was blocked |

## Verification
Debug entry and interrupt entry can both fall on the same instruction boundary. The bench provokes this by driving a break request and an enabled interrupt together, both with the boundary strobe. Each case is judged in two places. Before the edge, the combinational grant must be low. After the edge, the mode must be debug and the redirect must point at the break vector. A pending break that matures on a later boundary, while an interrupt is also asking, is handled the same way.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    CTX_SCRATCH = 2'd0,
    CTX_RETPC   = 2'd1,
    CTX_STAT    = 2'd2,
    CTX_NONE    = 2'd3
  } ctx_sel_e;

  localparam int unsigned BREAK_OFFSET = 32'h20;
endpackage

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req_i,
  input  logic insn_done_i,
  input  logic irq_req_i,
  input  logic irq_en_i,
  input  logic dret_i,
  output logic dbg_q_o,
  output logic enter_o,
  output logic leave_o,
  output logic irq_grant_o
);
  logic dbg_q, pend_q;

  assign enter_o     = !dbg_q && insn_done_i && (pend_q || halt_req_i);
  assign leave_o     = dbg_q && dret_i;
  assign irq_grant_o = irq_req_i && irq_en_i && insn_done_i && !dbg_q && !enter_o;
  assign dbg_q_o     = dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (enter_o)      dbg_q <= 1'b1;
      else if (leave_o) dbg_q <= 1'b0;

      if (enter_o || dbg_q) pend_q <= 1'b0;
      else if (halt_req_i)  pend_q <= 1'b1;
    end
  end

  assert_reset_normal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !dbg_q);
  assert_entry_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_q) |-> $past(insn_done_i));
  assert_halt_ignored_in_debug_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_q && !dret_i) |=> dbg_q);
  assert_debug_beats_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> !irq_grant_o);
endmodule

// File: rtl/dbg_ctx_regs.sv
module dbg_ctx_regs
  import dbg_entry_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode_i,
  input  logic              enter_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_sel_i,
  input  logic [ADDR_W-1:0] acc_wdata_i,
  output logic [ADDR_W-1:0] acc_rdata_o,
  output logic              acc_illegal_o,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic [STAT_W-1:0] saved_stat_o
);
  logic [ADDR_W-1:0] scratch_q, retpc_q;
  logic [STAT_W-1:0] stat_q;
  logic              illegal_q;
  logic              wr_req, wr_ok, mapped;
  ctx_sel_e          sel;

  assign sel    = ctx_sel_e'(acc_sel_i);
  assign mapped = (sel != CTX_NONE);
  assign wr_req = acc_valid_i && acc_write_i && mapped;
  assign wr_ok  = wr_req && dbg_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      retpc_q   <= '0;
      stat_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= wr_req && !dbg_mode_i;
      if (enter_i) begin
        retpc_q <= next_pc_i;
        stat_q  <= status_i;
      end else if (wr_ok) begin
        case (sel)
          CTX_SCRATCH: scratch_q <= acc_wdata_i;
          CTX_RETPC:   retpc_q   <= acc_wdata_i;
          CTX_STAT:    stat_q    <= acc_wdata_i[STAT_W-1:0];
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    acc_rdata_o = '0;
    if (dbg_mode_i) begin
      case (sel)
        CTX_SCRATCH: acc_rdata_o = scratch_q;
        CTX_RETPC:   acc_rdata_o = retpc_q;
        CTX_STAT:    acc_rdata_o = ADDR_W'(stat_q);
        default:     acc_rdata_o = '0;
      endcase
    end
  end

  assign acc_illegal_o = illegal_q;
  assign ret_pc_o      = retpc_q;
  assign saved_stat_o  = stat_q;

  assert_context_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (retpc_q == $past(next_pc_i)) && (stat_q == $past(status_i)));
  assert_normal_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode_i |-> acc_rdata_o == '0);
  assert_illegal_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $past(acc_valid_i && acc_write_i && !dbg_mode_i && mapped));
  assert_normal_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode_i && !enter_i) |=> $stable(scratch_q) && $stable(retpc_q) && $stable(stat_q));
endmodule

// File: rtl/dbg_redirect.sv
module dbg_redirect
  import dbg_entry_pkg::*;
#(
  parameter int unsigned    ADDR_W   = 32,
  parameter int unsigned    STAT_W   = 8,
  parameter logic [ADDR_W-1:0] DBG_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic [STAT_W-1:0] saved_stat_i,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_pc_o,
  output logic              stat_valid_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [ADDR_W-1:0] BREAK_VEC = DBG_BASE + ADDR_W'(BREAK_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      stat_valid_o  <= 1'b0;
      stat_o        <= '0;
    end else begin
      redir_valid_o <= enter_i || leave_i;
      stat_valid_o  <= leave_i;
      if (enter_i)      redir_pc_o <= BREAK_VEC;
      else if (leave_i) redir_pc_o <= ret_pc_i;
      if (leave_i)      stat_o     <= saved_stat_i;
    end
  end

  assert_break_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> redir_valid_o && (redir_pc_o == BREAK_VEC));
  assert_return_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    leave_i |=> redir_valid_o && stat_valid_o && (redir_pc_o == $past(ret_pc_i))
                && (stat_o == $past(saved_stat_i)));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       STAT_W   = 8,
  parameter logic [ADDR_W-1:0] DBG_BASE = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req_i,
  input  logic              insn_done_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              irq_req_i,
  input  logic              irq_en_i,
  output logic              irq_grant_o,
  input  logic              dret_i,
  output logic              dbg_mode_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              stat_restore_valid_o,
  output logic [STAT_W-1:0] stat_restore_o,
  input  logic              ctx_valid_i,
  input  logic              ctx_write_i,
  input  logic [1:0]        ctx_sel_i,
  input  logic [ADDR_W-1:0] ctx_wdata_i,
  output logic [ADDR_W-1:0] ctx_rdata_o,
  output logic              ctx_illegal_o
);
  logic              enter, leave, dbg_mode;
  logic [ADDR_W-1:0] ret_pc;
  logic [STAT_W-1:0] saved_stat;

  dbg_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req_i  (halt_req_i),
    .insn_done_i (insn_done_i),
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .dret_i      (dret_i),
    .dbg_q_o     (dbg_mode),
    .enter_o     (enter),
    .leave_o     (leave),
    .irq_grant_o (irq_grant_o)
  );

  dbg_ctx_regs #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_ctx (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_mode_i    (dbg_mode),
    .enter_i       (enter),
    .next_pc_i     (next_pc_i),
    .status_i      (status_i),
    .acc_valid_i   (ctx_valid_i),
    .acc_write_i   (ctx_write_i),
    .acc_sel_i     (ctx_sel_i),
    .acc_wdata_i   (ctx_wdata_i),
    .acc_rdata_o   (ctx_rdata_o),
    .acc_illegal_o (ctx_illegal_o),
    .ret_pc_o      (ret_pc),
    .saved_stat_o  (saved_stat)
  );

  dbg_redirect #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .DBG_BASE(DBG_BASE)) u_redir (
    .clk           (clk),
    .rst_n         (rst_n),
    .enter_i       (enter),
    .leave_i       (leave),
    .ret_pc_i      (ret_pc),
    .saved_stat_i  (saved_stat),
    .redir_valid_o (redirect_valid_o),
    .redir_pc_o    (redirect_pc_o),
    .stat_valid_o  (stat_restore_valid_o),
    .stat_o        (stat_restore_o)
  );

  assign dbg_mode_o = dbg_mode;

  assert_entry_redirects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode_o) |-> redirect_valid_o && !stat_restore_valid_o);
  assert_exit_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_mode_o) |-> redirect_valid_o && stat_restore_valid_o);
endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  localparam logic [31:0] BASE = 32'h0080_0000;
  localparam logic [31:0] BVEC = BASE + 32'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, insn_done = 0, irq_req = 0, irq_en = 0, dret = 0;
  logic [31:0] next_pc = '0;
  logic [7:0]  status = '0;
  logic ctx_valid = 0, ctx_write = 0;
  logic [1:0]  ctx_sel = '0;
  logic [31:0] ctx_wdata = '0;
  logic irq_grant, dbg_mode, redir_valid, stat_valid, ctx_illegal;
  logic [31:0] redir_pc, ctx_rdata;
  logic [7:0]  stat_out;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dbg_entry_ctrl #(.ADDR_W(32), .STAT_W(8), .DBG_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .insn_done_i(insn_done),
    .next_pc_i(next_pc), .status_i(status), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .irq_grant_o(irq_grant), .dret_i(dret), .dbg_mode_o(dbg_mode),
    .redirect_valid_o(redir_valid), .redirect_pc_o(redir_pc),
    .stat_restore_valid_o(stat_valid), .stat_restore_o(stat_out),
    .ctx_valid_i(ctx_valid), .ctx_write_i(ctx_write), .ctx_sel_i(ctx_sel),
    .ctx_wdata_i(ctx_wdata), .ctx_rdata_o(ctx_rdata), .ctx_illegal_o(ctx_illegal)
  );

  // {halt, done, irq, irq_en, exp_grant, exp_enter}
  localparam logic [5:0] VEC [0:7] = '{
    6'b011110, 6'b011000, 6'b111101, 6'b110001,
    6'b101100, 6'b000100, 6'b011101, 6'b010100
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    halt_req = 0; insn_done = 0; irq_req = 0; irq_en = 0; dret = 0;
    ctx_valid = 0; ctx_write = 0; ctx_sel = 2'd0; ctx_wdata = '0;
  endtask

  task automatic enter_dbg(input logic [31:0] pc, input logic [7:0] st);
    halt_req = 1; insn_done = 1; next_pc = pc; status = st;
    step();
    idle();
  endtask

  task automatic do_ret(input logic [31:0] pc, input logic [7:0] st, input string tag);
    dret = 1;
    step();
    dret = 0;
    chk({tag, " mode after return"}, 32'(dbg_mode), 32'd0);
    chk({tag, " return redirect"}, 32'(redir_valid), 32'd1);
    chk({tag, " return pc"}, redir_pc, pc);
    chk({tag, " restore valid"}, 32'(stat_valid), 32'd1);
    chk({tag, " restore status"}, 32'(stat_out), 32'(st));
  endtask

  initial begin
    #(20 * 50000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", 32'(dbg_mode), 32'd0);
    rst_n = 1;
    step();
    chk("R1 mode after reset", 32'(dbg_mode), 32'd0);
    chk("R1 redirect after reset", 32'(redir_valid), 32'd0);
    chk("R1 illegal after reset", 32'(ctx_illegal), 32'd0);

    // Table walk: arbitration between break entry and interrupt entry (R2 R3 R4 R5 R6 R8)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pc;
      logic [7:0]  st;
      pc = 32'h1000 + 32'(i) * 4;
      st = 8'h40 + 8'(i);
      halt_req = VEC[i][5]; insn_done = VEC[i][4]; irq_req = VEC[i][3]; irq_en = VEC[i][2];
      next_pc = pc; status = st;
      #1;
      chk($sformatf("R8 grant vec%0d", i), 32'(irq_grant), 32'(VEC[i][1]));
      step();
      idle();
      chk($sformatf("R2 R3 mode vec%0d", i), 32'(dbg_mode), 32'(VEC[i][0]));
      chk($sformatf("R4 redirect vec%0d", i), 32'(redir_valid), 32'(VEC[i][0]));
      if (VEC[i][0]) begin
        chk($sformatf("R4 vector vec%0d", i), redir_pc, BVEC);
        ctx_valid = 1; ctx_sel = 2'd1; #1;
        chk($sformatf("R5 saved pc vec%0d", i), ctx_rdata, pc);
        ctx_sel = 2'd2; #1;
        chk($sformatf("R5 saved status vec%0d", i), ctx_rdata, 32'(st));
        ctx_valid = 0;
        step();
        chk($sformatf("R4 one-cycle redirect vec%0d", i), 32'(redir_valid), 32'd0);
        do_ret(pc, st, $sformatf("R6 vec%0d", i));
        step();
      end
    end

    // R7: break request in debug is dropped
    enter_dbg(32'h1800, 8'h11);
    halt_req = 1; insn_done = 1;
    step();
    idle();
    chk("R7 still debug", 32'(dbg_mode), 32'd1);
    do_ret(32'h1800, 8'h11, "R7");
    insn_done = 1;
    repeat (3) step();
    insn_done = 0;
    chk("R7 no re-entry", 32'(dbg_mode), 32'd0);

    // R6: return strobe in normal mode
    dret = 1;
    step();
    dret = 0;
    chk("R6 normal dret mode", 32'(dbg_mode), 32'd0);
    chk("R6 normal dret no redirect", 32'(redir_valid), 32'd0);
    chk("R6 normal dret no restore", 32'(stat_valid), 32'd0);

    // R9/R10: normal-mode access
    ctx_valid = 1; ctx_sel = 2'd1; #1;
    chk("R9 normal read zero", ctx_rdata, 32'd0);
    ctx_write = 1; ctx_sel = 2'd0; ctx_wdata = 32'hDEAD_BEEF;
    step();
    ctx_valid = 0; ctx_write = 0;
    chk("R10 illegal flag", 32'(ctx_illegal), 32'd1);
    step();
    chk("R10 flag one cycle", 32'(ctx_illegal), 32'd0);
    ctx_valid = 1; ctx_write = 1; ctx_sel = 2'd3;
    step();
    idle();
    chk("R10 unmapped no flag", 32'(ctx_illegal), 32'd0);

    // R11: debug-mode writes; scratch still zero proves R10 drop
    enter_dbg(32'h2000, 8'h5A);
    ctx_valid = 1; ctx_sel = 2'd0; #1;
    chk("R10 scratch unchanged", ctx_rdata, 32'd0);
    ctx_write = 1; ctx_wdata = 32'h0000_1234;
    step();
    ctx_write = 0; #1;
    chk("R11 scratch written", ctx_rdata, 32'h0000_1234);
    chk("R11 no illegal in debug", 32'(ctx_illegal), 32'd0);
    ctx_write = 1; ctx_sel = 2'd1; ctx_wdata = 32'h0000_3000;
    step();
    ctx_write = 0; ctx_sel = 2'd3; #1;
    chk("R9 unmapped read zero", ctx_rdata, 32'd0);
    idle();
    do_ret(32'h0000_3000, 8'h5A, "R11");

    // R1: reset during a debug session
    step();
    enter_dbg(32'h4000, 8'h22);
    chk("R1 precondition debug", 32'(dbg_mode), 32'd1);
    rst_n = 0;
    #1;
    chk("R1 async reset mode", 32'(dbg_mode), 32'd0);
    step();
    rst_n = 1;
    step();
    chk("R1 mode after re-reset", 32'(dbg_mode), 32'd0);
    chk("R1 restore after re-reset", 32'(stat_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule